// File: doc/BRIEF.md
# Sixteen-bit CPU Register File with Packed Status Word

This block holds the architectural state of a small accumulator-style processor. Six data registers are kept: two operand registers feed the arithmetic unit and four more are for general storage. There is also a status word, a program counter, and a read-only view of the arithmetic result. Every register is 16 bits wide.

One synchronous write port takes a 4-bit index. One combinational read port takes a 4-bit index, and that index can also reach the arithmetic result. The status word has several writers. A general write updates its software-owned bits. Dedicated strobes each update one field. A toggle input flips the swap bit. The three arithmetic flags are captured from the arithmetic unit on every clock.

The program counter takes an explicit write through the normal index. When there is no explicit write, it can step forward by a supplied amount. The operand registers and the status word are always presented to the arithmetic unit. The swap bit drives its own output pin.

Top module: `cpu_regfile`

## Requirements
- R1: A synchronous active-low reset clears all six data registers, the status word and the program counter to zero on the first rising edge with `rst_n` low.
- R2: Write indices map as 0=A, 1=B, 2=C, 3=D, 4=E, 5=F, 6=status, 7=PC. A write with `wr_en` high lands on the next rising edge. `rd_data` shows the indexed register combinationally.
- R3: `io_sel_we` loads status bits 7:0 from `io_sel_val` and leaves all other bits alone. In the same cycle it overrides a general status write for those bits.
- R4: `alu_op_we` loads status bits 11:8 from `alu_op_val` and leaves all other bits alone. In the same cycle it overrides a general status write for those bits.
- R5: Status bit 12 is the swap flag, and `swap_out` always equals it. `swap_tgl` inverts the bit. When a general status write happens in the same cycle, the toggle applies to the newly written value.
- R6: Status bits 15, 14 and 13 take `alu_nzero`, `alu_zero` and `alu_carry` on every rising edge after reset. No register write changes these bits.
- R7: Read index 8 returns `alu_result` combinationally. Read indices 9 to 15 return zero.
- R8: A write with an index from 8 to 15 changes no register.
- R9: With `pc_inc_en` high and no explicit PC write, the PC becomes PC + `pc_inc_amt` modulo 2^16. With neither, the PC holds.
- R10: An explicit write to index 7 sets the PC to `wr_data` and overrides a same-cycle increment.
- R11: `op_a`, `op_b` and `status` always equal registers A, B and the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the indexed port |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 16 | Combinational read data |
| io_sel_we | input | 1 | IO select field write strobe |
| io_sel_val | input | 8 | IO select field value |
| alu_op_we | input | 1 | ALU operation field write strobe |
| alu_op_val | input | 4 | ALU operation field value |
| swap_tgl | input | 1 | Invert the swap flag |
| alu_result | input | 16 | Current arithmetic result |
| alu_carry | input | 1 | Carry flag from the arithmetic unit |
| alu_zero | input | 1 | Zero flag from the arithmetic unit |
| alu_nzero | input | 1 | Not-zero flag from the arithmetic unit |
| pc_inc_en | input | 1 | Advance the program counter |
| pc_inc_amt | input | 16 | Advance amount |
| op_a | output | 16 | Register A to the arithmetic unit |
| op_b | output | 16 | Register B to the arithmetic unit |
| status | output | 16 | Full status word |
| pc | output | 16 | Program counter |
| swap_out | output | 1 | Swap flag |

## Verification
Every piece of state sits behind a visible output. A wrong operand register, status bit or PC shows on `op_a`, `op_b`, `status`, `pc` or `swap_out` in the cycle right after the faulty edge. A wrong C to F register shows as soon as the read port selects it. A reference model in the bench tracks every register and compares each output, plus a randomly indexed read, on every cycle. A corrupted register is therefore caught within one cycle for the directly visible state. For the general registers it is caught at the next random read of that index, which typically comes within a few dozen cycles.

// File: rtl/regfile_pkg.sv
// Package: shared widths, index map and status-word field positions
// for the CPU register file. The field positions are decoded by the
// arithmetic unit and IO logic, so they are fixed here.
package regfile_pkg;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = 4;
    localparam int N_DATA  = 6;            // A, B, C, D, E, F
    localparam int IO_W    = 8;
    localparam int OP_W    = 4;
    localparam int SW_LO_W = 13;           // software-owned status bits 12:0

    // register index map
    localparam logic [IDX_W-1:0] IX_A  = 4'd0;
    localparam logic [IDX_W-1:0] IX_B  = 4'd1;
    localparam logic [IDX_W-1:0] IX_SR = 4'd6;
    localparam logic [IDX_W-1:0] IX_PC = 4'd7;
    localparam logic [IDX_W-1:0] IX_AO = 4'd8;

    // status field positions
    localparam int IO_LSB   = 0;
    localparam int OP_LSB   = 8;
    localparam int SWAP_BIT = 12;
    localparam int CY_BIT   = 13;
    localparam int ZR_BIT   = 14;
    localparam int NZ_BIT   = 15;

    typedef struct packed {
        logic nz;
        logic zr;
        logic cy;
    } alu_flags_t;
endpackage

// File: rtl/rf_data_bank.sv
// Module: rf_data_bank
// Holds the N plain data registers (operands and general storage).
// Assumes the caller supplies one-hot or zero write enables; a register
// whose enable is low holds its value. Synchronous active-low reset.
module rf_data_bank
    import regfile_pkg::*;
#(
    parameter int N = N_DATA,
    parameter int W = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        we,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        // one storage register, loaded when its enable is set
        always_ff @(posedge clk) begin
            if (!rst_n)     q[i] <= '0;
            else if (we[i]) q[i] <= wdata;
        end
    end

    // R2: decode never selects more than one register
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    // R8: a cycle with no enable leaves the whole bank unchanged
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we) == '0) |-> q == $past(q));
endmodule

// File: rtl/rf_status_reg.sv
// Module: rf_status_reg
// Status word with several writers. Bits 12:0 are software-owned:
// a general write loads them, and the field strobes override their own
// field. The swap toggle is applied last. Bits 15:13 are owned by
// hardware and reload from the arithmetic flags on every edge.
// Synchronous active-low reset.
module rf_status_reg
    import regfile_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_we,
    input  logic [SW_LO_W-1:0] gen_val,
    input  logic               io_we,
    input  logic [IO_W-1:0]    io_val,
    input  logic               op_we,
    input  logic [OP_W-1:0]    op_val,
    input  logic               swap_tgl,
    input  alu_flags_t         flags,
    output logic [DATA_W-1:0]  sr_q
);
    logic [SW_LO_W-1:0] lo_next;

    // merge the software writers in priority order
    always_comb begin
        lo_next = gen_we ? gen_val : sr_q[SW_LO_W-1:0];
        if (io_we) lo_next[IO_LSB +: IO_W] = io_val;
        if (op_we) lo_next[OP_LSB +: OP_W] = op_val;
        lo_next[SWAP_BIT] = lo_next[SWAP_BIT] ^ swap_tgl;
    end

    // register the merged software bits and the fresh hardware flags
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {flags.nz, flags.zr, flags.cy, lo_next};
    end

    // R6: hardware flags track the previous cycle's inputs
    p_flags_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sr_q[NZ_BIT:CY_BIT] == $past(flags));

    // R3: the IO strobe loads its field
    p_io_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(io_we)) |-> sr_q[IO_LSB +: IO_W] == $past(io_val));

    // R4: the operation strobe loads its field
    p_op_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_we)) |-> sr_q[OP_LSB +: OP_W] == $past(op_val));

    // R5: a lone toggle inverts the swap flag
    p_swap_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(swap_tgl) && !$past(gen_we))
        |-> sr_q[SWAP_BIT] != $past(sr_q[SWAP_BIT]));
endmodule

// File: rtl/rf_pc_reg.sv
// Module: rf_pc_reg
// Program counter. An explicit load wins; otherwise an enabled step adds
// the supplied amount with wrap-around; otherwise it holds.
// Synchronous active-low reset.
module rf_pc_reg
    import regfile_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    input  logic [W-1:0] step_amt,
    output logic [W-1:0] pc_q
);
    // choose between load, step and hold
    always_ff @(posedge clk) begin
        if (!rst_n)    pc_q <= '0;
        else if (ld)   pc_q <= ld_val;
        else if (step) pc_q <= pc_q + step_amt;
    end

    // R10: a load always takes the written value
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld)) |-> pc_q == $past(ld_val));

    // R9: with neither load nor step the counter holds
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld) && !$past(step)) |-> $stable(pc_q));
endmodule

// File: rtl/cpu_regfile.sv
// Module: cpu_regfile (top)
// CPU register file: six data registers, status word, program counter
// and a read-only view of the arithmetic result on the read port.
// Decodes the write index into per-register enables and muxes the read
// index. Assumes the flags and result come straight from the arithmetic
// unit. Synchronous active-low reset.
module cpu_regfile
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              io_sel_we,
    input  logic [IO_W-1:0]   io_sel_val,
    input  logic              alu_op_we,
    input  logic [OP_W-1:0]   alu_op_val,
    input  logic              swap_tgl,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_zero,
    input  logic              alu_nzero,
    input  logic              pc_inc_en,
    input  logic [DATA_W-1:0] pc_inc_amt,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] pc,
    output logic              swap_out
);
    logic [N_DATA-1:0]              data_we;
    logic [N_DATA-1:0][DATA_W-1:0]  data_q;
    logic                           sr_we;
    logic                           pc_we;
    alu_flags_t                     flags;

    // decode the write index into one enable per register
    always_comb begin
        for (int i = 0; i < N_DATA; i++)
            data_we[i] = wr_en && (wr_idx == IDX_W'(i));
        sr_we = wr_en && (wr_idx == IX_SR);
        pc_we = wr_en && (wr_idx == IX_PC);
    end

    // bundle the arithmetic flags
    always_comb begin
        flags.nz = alu_nzero;
        flags.zr = alu_zero;
        flags.cy = alu_carry;
    end

    rf_data_bank #(.N(N_DATA), .W(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_we),
        .wdata (wr_data),
        .q     (data_q)
    );

    rf_status_reg u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_we   (sr_we),
        .gen_val  (wr_data[SW_LO_W-1:0]),
        .io_we    (io_sel_we),
        .io_val   (io_sel_val),
        .op_we    (alu_op_we),
        .op_val   (alu_op_val),
        .swap_tgl (swap_tgl),
        .flags    (flags),
        .sr_q     (status)
    );

    rf_pc_reg #(.W(DATA_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (pc_we),
        .ld_val   (wr_data),
        .step     (pc_inc_en),
        .step_amt (pc_inc_amt),
        .pc_q     (pc)
    );

    // read-port multiplexer over the full index space
    always_comb begin
        if (rd_idx < IDX_W'(N_DATA))
            rd_data = data_q[rd_idx[2:0]];
        else if (rd_idx == IX_SR)
            rd_data = status;
        else if (rd_idx == IX_PC)
            rd_data = pc;
        else if (rd_idx == IX_AO)
            rd_data = alu_result;
        else
            rd_data = '0;
    end

    // fixed taps to the arithmetic unit and the swap pin
    always_comb begin
        op_a     = data_q[IX_A[2:0]];
        op_b     = data_q[IX_B[2:0]];
        swap_out = status[SWAP_BIT];
    end

    // R8: a write aimed past index 7 leaves every data register unchanged
    p_high_idx_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_idx) > IX_PC)
        |-> data_q == $past(data_q));

    // R6: a general status write never disturbs the flag bits
    p_flags_not_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sr_we))
        |-> status[NZ_BIT:CY_BIT] == $past({alu_nzero, alu_zero, alu_carry}));
endmodule

// File: tb/tb_cpu_regfile.sv
`timescale 1ns/1ps
module tb_cpu_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        io_sel_we = 1'b0;
    logic [7:0]  io_sel_val = '0;
    logic        alu_op_we = 1'b0;
    logic [3:0]  alu_op_val = '0;
    logic        swap_tgl = 1'b0;
    logic [15:0] alu_result = '0;
    logic        alu_carry = 1'b0, alu_zero = 1'b0, alu_nzero = 1'b0;
    logic        pc_inc_en = 1'b0;
    logic [15:0] pc_inc_amt = '0;
    logic [15:0] op_a, op_b, status, pc;
    logic        swap_out;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [15:0] m_reg [0:7];   // 0-5 data, 6 status, 7 pc
    logic [15:0] n_reg [0:7];

    always #2.5 clk = ~clk;

    cpu_regfile dut (.*);

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [3:0] idx);
        if (idx < 4'd8)       return m_reg[idx[2:0]];
        else if (idx == 4'd8) return alu_result;
        else                  return 16'h0000;
    endfunction

    // compare every visible output with the model under current inputs
    task automatic compare_all();
        logic [15:0] e;
        e = model_read(rd_idx);
        chk(rd_data === e, (rd_idx >= 4'd8) ? "R7 read" : "R2 read", rd_data, e);
        chk(op_a === m_reg[0], "R11 op_a", op_a, m_reg[0]);
        chk(op_b === m_reg[1], "R11 op_b", op_b, m_reg[1]);
        chk(status[7:0] === m_reg[6][7:0], "R3 io field", {8'h0, status[7:0]}, {8'h0, m_reg[6][7:0]});
        chk(status[11:8] === m_reg[6][11:8], "R4 op field", {12'h0, status[11:8]}, {12'h0, m_reg[6][11:8]});
        chk(swap_out === m_reg[6][12] && status[12] === m_reg[6][12], "R5 swap",
            {15'h0, swap_out}, {15'h0, m_reg[6][12]});
        chk(status[15:13] === m_reg[6][15:13], "R6 flags", {13'h0, status[15:13]}, {13'h0, m_reg[6][15:13]});
        chk(pc === m_reg[7], "R9 R10 pc", pc, m_reg[7]);
    endtask

    // compute the model's next state from the current inputs
    task automatic model_next();
        logic [12:0] lo;
        for (int i = 0; i < 8; i++) n_reg[i] = m_reg[i];
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) n_reg[i] = 16'h0;
            return;
        end
        for (int i = 0; i < 6; i++)
            if (wr_en && wr_idx == 4'(i)) n_reg[i] = wr_data;
        lo = (wr_en && wr_idx == 4'd6) ? wr_data[12:0] : m_reg[6][12:0];
        if (io_sel_we) lo[7:0] = io_sel_val;
        if (alu_op_we) lo[11:8] = alu_op_val;
        lo[12] = lo[12] ^ swap_tgl;
        n_reg[6] = {alu_nzero, alu_zero, alu_carry, lo};
        if (wr_en && wr_idx == 4'd7) n_reg[7] = wr_data;
        else if (pc_inc_en)          n_reg[7] = m_reg[7] + pc_inc_amt;
    endtask

    // called just after a falling edge with inputs set: check, then clock
    task automatic tick();
        #1;
        compare_all();
        model_next();
        @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) m_reg[i] = n_reg[i];
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_en = 0; io_sel_we = 0; alu_op_we = 0; swap_tgl = 0; pc_inc_en = 0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [15:0] d);
        idle_inputs(); wr_en = 1; wr_idx = idx; wr_data = d; tick(); idle_inputs();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 16'hxxxx;
        // pre-load garbage then reset
        @(negedge clk);
        rst_n = 1; wr_en = 1; wr_idx = 4'd3; wr_data = 16'hBEEF;
        @(negedge clk);
        rst_n = 0; wr_en = 0;
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
        @(negedge clk);
        // R1: everything zero after reset
        for (int i = 0; i < 8; i++) begin
            rd_idx = 4'(i); #1;
            chk(rd_data === 16'h0, "R1 reset", rd_data, 16'h0);
        end
        rst_n = 1;

        // R2: write each data register, read it back
        for (int i = 0; i < 6; i++) wr(4'(i), 16'h1111 * 16'(i + 1));
        for (int i = 0; i < 6; i++) begin rd_idx = 4'(i); tick(); end
        // R8: writes to 8..15 ignored
        for (int i = 8; i < 16; i++) wr(4'(i), 16'hDEAD);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 4'(i); #1;
            chk(rd_data === m_reg[i], "R8 ignored write", rd_data, m_reg[i]);
        end
        // R7: result view and zero indices
        alu_result = 16'h5A5A; rd_idx = 4'd8; #1;
        chk(rd_data === 16'h5A5A, "R7 result view", rd_data, 16'h5A5A);
        rd_idx = 4'd12; #1;
        chk(rd_data === 16'h0, "R7 unused index", rd_data, 16'h0);
        // R3 R4 R5: strobes override a same-cycle general status write
        idle_inputs(); wr_en = 1; wr_idx = 4'd6; wr_data = 16'hFFFF;
        io_sel_we = 1; io_sel_val = 8'h3C; alu_op_we = 1; alu_op_val = 4'h5;
        swap_tgl = 1; tick(); idle_inputs();
        chk(status[12:0] === 13'h053C, "R3 R4 R5 merge", {3'b0, status[12:0]}, 16'h053C);
        // R6: flags follow the inputs, general write cannot set them
        alu_nzero = 1; alu_zero = 0; alu_carry = 1;
        wr(4'd6, 16'h0000);
        chk(status[15:13] === 3'b101, "R6 flags capture", {13'h0, status[15:13]}, 16'h0005);
        // R5: lone toggle
        swap_tgl = 1; tick(); idle_inputs();
        chk(swap_out === 1'b1, "R5 toggle", {15'h0, swap_out}, 16'h1);
        // R9: increment with wrap
        wr(4'd7, 16'hFFFE);
        pc_inc_en = 1; pc_inc_amt = 16'h0003; tick(); idle_inputs();
        chk(pc === 16'h0001, "R9 wrap", pc, 16'h0001);
        // R10: write beats increment
        wr_en = 1; wr_idx = 4'd7; wr_data = 16'h0100; pc_inc_en = 1; tick(); idle_inputs();
        chk(pc === 16'h0100, "R10 priority", pc, 16'h0100);

        // random phase, compared every cycle
        for (int n = 0; n < 3000; n++) begin
            wr_en      = ($urandom % 3) == 0;
            wr_idx     = 4'($urandom);
            wr_data    = 16'($urandom);
            rd_idx     = 4'($urandom);
            io_sel_we  = ($urandom % 4) == 0;
            io_sel_val = 8'($urandom);
            alu_op_we  = ($urandom % 4) == 0;
            alu_op_val = 4'($urandom);
            swap_tgl   = ($urandom % 4) == 0;
            alu_result = 16'($urandom);
            {alu_nzero, alu_zero, alu_carry} = 3'($urandom);
            pc_inc_en  = ($urandom % 2) == 0;
            pc_inc_amt = 16'($urandom % 5);
            rst_n      = ($urandom % 200) != 0;
            tick();
        end
        rst_n = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule